// File: doc/BRIEF.md
# Serial Host Write Receiver

This block accepts write-only traffic from a host microcontroller over a clocked serial link and turns it into whole bytes inside a fast system clock domain. Every byte carries a type flag. A set flag means the byte is pixel data for the display memory. A clear flag means the byte is for the command register. The block does not decode commands, does not read back and has no parallel bus.

A static mode input picks the framing. In pin-flag mode each byte is eight bits. A separate type pin gives the flag, and it is taken in together with the eighth bit. In in-band mode each transfer is nine bits. The first bit is the type flag and the eight payload bits follow it. Both modes shift the payload most significant bit first, on rising edges of the serial clock, and only while the active-low select is asserted.

The serial clock, serial data, select and type pin all pass through multi-stage synchronisers. A rising edge of the serial clock is then found in the system domain, so the system clock must run at least four times faster than the serial clock. The host must also wait at least one serial half-period after asserting select before the first rising edge.

The frame controller has three states:
- `ST_IDLE`: select is released.
- `ST_FLAG`: in-band mode, waiting for the type bit.
- `ST_SHIFT`: collecting payload bits.

Its transitions are:
- IDLE→FLAG on select asserted in in-band mode.
- IDLE→SHIFT on select asserted in pin-flag mode.
- FLAG→SHIFT on a clock edge.
- SHIFT→FLAG on the final payload edge in in-band mode.
- SHIFT→SHIFT on the final edge in pin-flag mode, with the counter wrapping.
- Any state→IDLE whenever select is released.

Top module: `ser_wr_rx`

## Requirements
- R1: In pin-flag mode (`mode_inband`=0), eight serial bits are captured on rising `sclk` edges, first bit into `rx_byte[7]` and last into `rx_byte[0]`, and one `rx_vld` strobe presents the byte.
- R2: In pin-flag mode, `rx_is_data` equals the level of `dc_pin` at the eighth rising edge of that byte; its level at earlier edges has no effect.
- R3: In in-band mode (`mode_inband`=1), a transfer is nine rising edges: the first bit is the type flag, the next eight are the payload MSB first, and the strobe follows the ninth edge.
- R4: A type flag of 1 gives `rx_is_data`=1 (display memory) and 0 gives `rx_is_data`=0 (command register), in both modes.
- R5: `sclk` edges while `cs_n` is high produce no strobe and leave no bits behind for the next byte.
- R6: Releasing `cs_n` in the middle of a transfer discards the partial bits; the next transfer starts from its first bit after `cs_n` falls again.
- R7: With `cs_n` held low, consecutive transfers follow each other without gaps and the bit counter wraps after 8 (pin-flag) or 9 (in-band) edges.
- R8: `rx_vld` is high for exactly one system clock per completed transfer.
- R9: While `rst_n` is low, `rx_vld`, `rx_byte` and `rx_is_data` are 0, and bits shifted before the reset are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_inband | input | 1 | Framing select: 0 pin-flag 8-bit, 1 in-band 9-bit; change only while `cs_n` is high |
| sclk | input | 1 | Serial clock from host, bits taken on its rising edge |
| sdin | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low select |
| dc_pin | input | 1 | Type pin used in pin-flag mode (1 data, 0 command) |
| rx_vld | output | 1 | One-cycle strobe marking a completed byte |
| rx_byte | output | 8 | Received payload byte |
| rx_is_data | output | 1 | Type of the byte: 1 display data, 0 command |

## Verification
The bench builds the block with its default parameters: an 8-bit payload and two synchroniser stages. It drives a serial clock eight times slower than the system clock, which keeps every edge well inside the oversampling limit. With these values a single transfer is short, so the bench can send bytes back to back in both framings within one select window. It can also cut a transfer after a few bits, move the type pin between edges, and reset the block in the middle of a byte.

// File: rtl/ser_wr_rx_pkg.sv
package ser_wr_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLAG  = 2'd1,
        ST_SHIFT = 2'd2
    } rx_state_e;

endpackage

// File: rtl/ser_wr_sync.sv
module ser_wr_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ser_wr_deframer.sv
module ser_wr_deframer
    import ser_wr_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_inband,
    input  logic              sel_act,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic              dc_val,
    output logic              rx_vld,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_is_data
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    rx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flag_q;
    logic              last_bit;
    logic [DATA_W-1:0] shifted;

    assign last_bit = (cnt_q == LAST_IDX);
    assign shifted  = {shreg_q[DATA_W-2:0], bit_val};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_act) begin
                    state_d = mode_inband ? ST_FLAG : ST_SHIFT;
                end
            end
            ST_FLAG: begin
                if (!sel_act) begin
                    state_d = ST_IDLE;
                end else if (bit_rise) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!sel_act) begin
                    state_d = ST_IDLE;
                end else if (bit_rise && last_bit) begin
                    state_d = mode_inband ? ST_FLAG : ST_SHIFT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            flag_q     <= 1'b0;
            rx_vld     <= 1'b0;
            rx_byte    <= '0;
            rx_is_data <= 1'b0;
        end else begin
            rx_vld <= 1'b0;
            if (!sel_act || state_q == ST_IDLE) begin
                shreg_q <= '0;
                cnt_q   <= '0;
            end else if (bit_rise) begin
                if (state_q == ST_FLAG) begin
                    flag_q <= bit_val;
                    cnt_q  <= '0;
                end else begin
                    shreg_q <= shifted;
                    if (last_bit) begin
                        cnt_q      <= '0;
                        rx_vld     <= 1'b1;
                        rx_byte    <= shifted;
                        rx_is_data <= mode_inband ? flag_q : dc_val;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ser_wr_rx.sv
module ser_wr_rx
    import ser_wr_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_inband,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              cs_n,
    input  logic              dc_pin,
    output logic              rx_vld,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_is_data
);

    localparam int PINS = 4;

    logic [PINS-1:0] pins_raw, pins_s;
    logic            sclk_s, sdin_s, cs_s, dc_s;
    logic            sclk_prev_q;
    logic            sclk_rise;

    assign pins_raw = {dc_pin, cs_n, sdin, sclk};

    ser_wr_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign {dc_s, cs_s, sdin_s, sclk_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;

    ser_wr_deframer #(
        .DATA_W(DATA_W)
    ) u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_inband(mode_inband),
        .sel_act    (~cs_s),
        .bit_rise   (sclk_rise),
        .bit_val    (sdin_s),
        .dc_val     (dc_s),
        .rx_vld     (rx_vld),
        .rx_byte    (rx_byte),
        .rx_is_data (rx_is_data)
    );

endmodule

// File: rtl/ser_wr_rx_chk.sv
module ser_wr_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              sclk_rise,
    input logic              rx_vld,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_is_data
);

    // R8: strobe never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> !rx_vld);

    // R5: a synchronised released select blocks the next strobe
    a_r5_cs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !rx_vld);

    // R1: every strobe follows a detected serial clock edge
    a_r1_strobe_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> !rx_vld);

    // R9: outputs quiet during reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!rx_vld && rx_byte == '0 && !rx_is_data));

endmodule

bind ser_wr_rx ser_wr_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sclk_rise (sclk_rise),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .rx_is_data(rx_is_data)
);

// File: tb/ser_wr_rx_tb.sv
`timescale 1ns/1ps
module ser_wr_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_inband = 1'b0;
    logic       sclk = 1'b0;
    logic       sdin = 1'b0;
    logic       cs_n = 1'b1;
    logic       dc_pin = 1'b0;
    logic       rx_vld;
    logic [7:0] rx_byte;
    logic       rx_is_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] cap_byte [16];
    logic       cap_flag [16];
    int         cap_n = 0;
    int         dbl_pulse = 0;
    logic       vld_prev = 1'b0;

    always #5 clk = ~clk;

    ser_wr_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_inband(mode_inband),
        .sclk       (sclk),
        .sdin       (sdin),
        .cs_n       (cs_n),
        .dc_pin     (dc_pin),
        .rx_vld     (rx_vld),
        .rx_byte    (rx_byte),
        .rx_is_data (rx_is_data)
    );

    always @(negedge clk) begin
        if (rx_vld === 1'b1) begin
            if (cap_n < 16) begin
                cap_byte[cap_n] = rx_byte;
                cap_flag[cap_n] = rx_is_data;
            end
            cap_n++;
            if (vld_prev) dbl_pulse++;
        end
        vld_prev = (rx_vld === 1'b1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b);
        sdin = b;
        #40 sclk = 1'b1;
        #40 sclk = 1'b0;
    endtask

    task automatic send8(input logic [7:0] v, input logic dc);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) dc_pin = dc;
            clk_bit(v[i]);
        end
    endtask

    task automatic sel_low();
        cs_n = 1'b0;
        #80;
    endtask

    task automatic sel_high();
        #80 cs_n = 1'b1;
        #80;
    endtask

    task automatic expect_caps(input int n, input string req);
        chk(cap_n == n, req, cap_n, n);
    endtask

    task automatic expect_cap(input int idx, input logic [7:0] v, input logic f, input string req);
        chk(cap_byte[idx] == v, req, cap_byte[idx], v);
        chk(cap_flag[idx] == f, req, cap_flag[idx], f);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rx_vld == 1'b0, "R9 vld in reset", rx_vld, 0);
        chk(rx_byte == 8'h00, "R9 byte in reset", rx_byte, 0);
        chk(rx_is_data == 1'b0, "R9 flag in reset", rx_is_data, 0);
        rst_n = 1'b1;
        #100;
        // R9: reset mid-byte loses earlier bits
        sel_low();
        clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1);
        rst_n = 1'b0;
        #50;
        chk(rx_vld == 1'b0 && rx_byte == 8'h00, "R9 mid-byte reset", rx_byte, 0);
        rst_n = 1'b1;
        #80;
        cap_n = 0;
        send8(8'h0F, 1'b1);
        sel_high();
        expect_caps(1, "R9 count after reset");
        expect_cap(0, 8'h0F, 1'b1, "R9 byte after reset");
    endtask

    task automatic t_pin_flag_stream();
        mode_inband = 1'b0;
        cap_n = 0;
        sel_low();
        send8(8'hA5, 1'b1);
        send8(8'h3C, 1'b0);
        send8(8'h81, 1'b1);
        sel_high();
        expect_caps(3, "R7 pin-flag stream count");
        expect_cap(0, 8'hA5, 1'b1, "R1 R4 first byte");
        expect_cap(1, 8'h3C, 1'b0, "R1 R4 command byte");
        expect_cap(2, 8'h81, 1'b1, "R7 third byte");
    endtask

    task automatic t_dc_late();
        mode_inband = 1'b0;
        cap_n = 0;
        sel_low();
        dc_pin = 1'b1;
        for (int i = 7; i >= 1; i--) clk_bit(1'b0);
        dc_pin = 1'b0;
        clk_bit(1'b1);
        dc_pin = 1'b0;
        for (int i = 7; i >= 1; i--) clk_bit(i[0]);
        dc_pin = 1'b1;
        clk_bit(1'b0);
        sel_high();
        expect_caps(2, "R2 count");
        expect_cap(0, 8'h01, 1'b0, "R2 dc low at eighth bit");
        expect_cap(1, 8'hAA, 1'b1, "R2 dc high at eighth bit");
    endtask

    task automatic t_inband();
        mode_inband = 1'b1;
        dc_pin = 1'b0;
        cap_n = 0;
        sel_low();
        clk_bit(1'b1); send8(8'hC3, 1'b0);
        clk_bit(1'b0); send8(8'h7E, 1'b1);
        sel_high();
        expect_caps(2, "R3 in-band count");
        expect_cap(0, 8'hC3, 1'b1, "R3 R4 data flag in-band");
        expect_cap(1, 8'h7E, 1'b0, "R3 R4 command flag ignores pin");
        mode_inband = 1'b0;
    endtask

    task automatic t_cs_gate();
        mode_inband = 1'b0;
        cap_n = 0;
        for (int i = 0; i < 11; i++) clk_bit(1'b1);
        chk(cap_n == 0, "R5 no strobe with select high", cap_n, 0);
        sel_low();
        send8(8'h12, 1'b0);
        sel_high();
        expect_caps(1, "R5 count after idle edges");
        expect_cap(0, 8'h12, 1'b0, "R5 no leftover bits");
    endtask

    task automatic t_abort();
        mode_inband = 1'b0;
        cap_n = 0;
        sel_low();
        for (int i = 0; i < 5; i++) clk_bit(1'b1);
        sel_high();
        sel_low();
        send8(8'h96, 1'b1);
        sel_high();
        expect_caps(1, "R6 pin-flag abort count");
        expect_cap(0, 8'h96, 1'b1, "R6 pin-flag restart");
        mode_inband = 1'b1;
        cap_n = 0;
        sel_low();
        clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0);
        sel_high();
        sel_low();
        clk_bit(1'b0); send8(8'h5A, 1'b1);
        sel_high();
        expect_caps(1, "R6 in-band abort count");
        expect_cap(0, 8'h5A, 1'b0, "R6 in-band restart");
        mode_inband = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        t_pin_flag_stream();
        t_dc_late();
        t_inband();
        t_cs_gate();
        t_abort();
        chk(dbl_pulse == 0, "R8 single-cycle strobe", dbl_pulse, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule